// File: doc/BRIEF.md
# Two-Page I2C Configuration Register Target

This block is an I2C target that gives a host controller access to a set of 8-bit configuration registers held in two pages. One register, at index 0, selects the active page and can be reached from both pages. The host addresses the target with a 7-bit device address, sends a register pointer, and then writes data bytes or reads data back after a repeated START. The pointer moves forward by one after every byte.

SCL and SDA are sampled in the system clock domain through two-flop synchronizers. START and STOP are found as SDA edges while SCL is high. The target pulls SDA low through an open-drain output enable. On the core side there is a combinational read port for every register. There is also a load port for the read-only status registers, which the host can read but cannot change.

Top module: `i2c_paged_regs`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal DEV_ADDR (bit 0 = 1 for read). On any other address it does not acknowledge, and it ignores all traffic until the next START.
- R2: In a write transaction, the first byte after the address loads the pointer from its low PTR_W bits. Each later byte is acknowledged and written to the register at the pointer, and the pointer then advances by one, wrapping from 2**PTR_W-1 to 0.
- R3: Index 0 is the page-select register in both pages. Bit 0 of a byte written there selects page 0 or page 1, and the other bits are discarded. A read of index 0 returns 7'b0 followed by the page bit.
- R4: Indices 1 to 2**PTR_W-1 have separate storage in each page. A write reaches only the page that is active when the byte completes.
- R5: Registers flagged in RO_P0 / RO_P1 are read-only for the host. Host writes to them are still acknowledged and still advance the pointer, but they leave the value unchanged. The core sets these registers through the status load port, and the host can read them.
- R6: A read addressed after a repeated START (or a new START) returns bytes MSB first, beginning at the current pointer. The pointer advances after each byte the host acknowledges. When the host NACKs, SDA is released and the pointer stays where it was.
- R7: A START at any point, even mid-byte, restarts address reception. A STOP returns the target to idle. Both leave SDA released.
- R8: The SDA output enable changes only while the synchronized SCL is low.
- R9: After reset, SDA is released, page 0 is active and every register reads 0x00.
- R10: The core read port returns, in the same cycle, the register selected by core_rd_page and core_rd_idx, including values the host has just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | I2C clock line, asynchronous |
| sda_in | input | 1 | I2C data line as seen on the pin, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| core_rd_page | input | 1 | Page for the core read port |
| core_rd_idx | input | PTR_W | Register index for the core read port |
| core_rd_data | output | 8 | Register value for the core read port |
| st_we | input | 1 | Status load strobe for read-only registers |
| st_page | input | 1 | Page of the status register to load |
| st_idx | input | PTR_W | Index of the status register to load |
| st_data | input | 8 | Value to load |

## Verification
Write bursts of different lengths, starting at different pointers, check that the pointer loads and then advances per byte, and one burst wraps through index 0 so that it flips the page part-way through. Reads after a repeated START, with the last byte NACKed and then followed by a pointer-less read, show whether the pointer advances on an ACK only. A wrong device address followed by more bytes, a START that cuts a byte short and a STOP in the middle of a byte show that half-finished traffic never reaches the registers. Writing the same index on both pages, and writing over read-only registers, tells page-local storage and write protection apart from a plain register file.

// File: rtl/i2c_preg_pkg.sv
// Shared types for the paged I2C register target.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_preg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_TX,
        ST_TX,
        ST_ACK_RX
    } eng_state_t;

    typedef enum logic [1:0] {
        BY_ADDR,
        BY_PTR,
        BY_DATA
    } byte_kind_t;

endpackage

// File: rtl/i2c_preg_sync.sv
// Synchronizes SCL/SDA into clk and reports SCL edges and bus conditions.
// Assumes: both lines idle high; STAGES >= 2 flops per line.
module i2c_preg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_preg_engine.sv
// Byte-level I2C target protocol: address match, pointer load, writes
// with pointer increment, reads with host ACK handling.
// Assumes: inputs come from i2c_preg_sync; rd_data is combinational from rd_idx.
module i2c_preg_engine
    import i2c_preg_pkg::*;
#(
    parameter int         PTR_W    = 4,
    parameter logic [6:0] DEV_ADDR = 7'h18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    eng_state_t       state;
    byte_kind_t       kind;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic [PTR_W-1:0] ptr;
    logic             rnw;
    logic             host_ack;

    // Read index: the next register when a host ACK is about to advance.
    assign rd_idx = (state == ST_ACK_RX) ? ptr + 1'b1 : ptr;

    // Protocol sequencer; bus conditions override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind     <= BY_ADDR;
            bitcnt   <= '0;
            shreg    <= '0;
            ptr      <= '0;
            rnw      <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= ST_RX;
                kind   <= BY_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            case (kind)
                                BY_ADDR: begin
                                    if (shreg[7:1] == DEV_ADDR) begin
                                        rnw    <= shreg[0];
                                        sda_oe <= 1'b1;
                                        state  <= ST_ACK_TX;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                BY_PTR: begin
                                    ptr    <= shreg[PTR_W-1:0];
                                    kind   <= BY_DATA;
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK_TX;
                                end
                                default: begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= ptr;
                                    wr_data <= shreg;
                                    ptr     <= ptr + 1'b1;
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ACK_TX;
                                end
                            endcase
                        end
                    end
                    ST_ACK_TX: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (kind == BY_ADDR && rnw) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RX;
                                if (kind == BY_ADDR) kind <= BY_PTR;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_ACK_RX;
                            end else begin
                                bitcnt <= bitcnt + 4'd1;
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    ST_ACK_RX: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                ptr    <= ptr + 1'b1;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                bitcnt <= '0;
                                state  <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_preg_bank.sv
// Two-page register storage with a shared page-select at index 0 and
// per-page read-only masks; read-only cells load only from the core.
// Assumes: host and core never target the same cell (masks keep them apart).
module i2c_preg_bank #(
    parameter int                      PTR_W = 4,
    parameter logic [(2**PTR_W)-1:0]   RO_P0 = 16'hC000,
    parameter logic [(2**PTR_W)-1:0]   RO_P1 = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             st_we,
    input  logic             st_page,
    input  logic [PTR_W-1:0] st_idx,
    input  logic [7:0]       st_data,
    input  logic [PTR_W-1:0] host_idx,
    output logic [7:0]       host_rdata,
    input  logic             core_page,
    input  logic [PTR_W-1:0] core_idx,
    output logic [7:0]       core_rdata,
    output logic             page
);
    localparam int NREG = 2 ** PTR_W;

    logic [7:0] cell_q [2*NREG];

    // Page-select register, written by the host from either page.
    always_ff @(posedge clk) begin
        if (!rst_n)                         page <= 1'b0;
        else if (wr_en && wr_idx == '0)     page <= wr_data[0];
    end

    for (genvar g = 0; g < 2; g++) begin : g_page
        localparam logic [NREG-1:0] ROM = (g == 0) ? RO_P0 : RO_P1;
        for (genvar i = 0; i < NREG; i++) begin : g_cell
            if (i == 0) begin : g_sel
                assign cell_q[g*NREG+i] = 8'h00;
            end else if (ROM[i]) begin : g_ro
                logic [7:0] q;
                // Status cell: loaded by the core only.
                always_ff @(posedge clk) begin
                    if (!rst_n) q <= 8'h00;
                    else if (st_we && st_page == 1'(g) && st_idx == PTR_W'(i)) q <= st_data;
                end
                assign cell_q[g*NREG+i] = q;
            end else begin : g_rw
                logic [7:0] q;
                // Configuration cell: written by the host on the active page.
                always_ff @(posedge clk) begin
                    if (!rst_n) q <= 8'h00;
                    else if (wr_en && page == 1'(g) && wr_idx == PTR_W'(i)) q <= wr_data;
                end
                assign cell_q[g*NREG+i] = q;
            end
        end
    end

    assign host_rdata = (host_idx == '0) ? {7'b0, page} : cell_q[{page, host_idx}];
    assign core_rdata = (core_idx == '0) ? {7'b0, page} : cell_q[{core_page, core_idx}];

endmodule

// File: rtl/i2c_paged_regs.sv
// Top of the paged I2C register target: line sync, protocol engine, storage.
// Assumes: sda_oe drives an open-drain pad; SCL is never stretched.
module i2c_paged_regs #(
    parameter logic [6:0]            DEV_ADDR = 7'h18,
    parameter int                    PTR_W    = 4,
    parameter logic [(2**PTR_W)-1:0] RO_P0    = 16'hC000,
    parameter logic [(2**PTR_W)-1:0] RO_P1    = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    input  logic             core_rd_page,
    input  logic [PTR_W-1:0] core_rd_idx,
    output logic [7:0]       core_rd_data,
    input  logic             st_we,
    input  logic             st_page,
    input  logic [PTR_W-1:0] st_idx,
    input  logic [7:0]       st_data
);
    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [PTR_W-1:0] rd_idx, wr_idx;
    logic [7:0]       rd_data, wr_data;
    logic             wr_en, page;

    i2c_preg_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_preg_engine #(.PTR_W(PTR_W), .DEV_ADDR(DEV_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .sda_oe(sda_oe)
    );

    i2c_preg_bank #(.PTR_W(PTR_W), .RO_P0(RO_P0), .RO_P1(RO_P1)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .st_we(st_we), .st_page(st_page), .st_idx(st_idx), .st_data(st_data),
        .host_idx(rd_idx), .host_rdata(rd_data), .core_page(core_rd_page),
        .core_idx(core_rd_idx), .core_rdata(core_rd_data), .page(page)
    );

endmodule

// File: rtl/i2c_paged_regs_chk.sv
// Protocol checker for i2c_paged_regs, attached by bind.
// Assumes: connected to the top's internal synchronized and write signals.
module i2c_paged_regs_chk #(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             start_det,
    input logic             stop_det,
    input logic             sda_oe,
    input logic             wr_en,
    input logic [PTR_W-1:0] wr_idx,
    input logic             page
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s)); // R8
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe); // R7
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R7
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R2
    AST_PAGE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(page) |-> $past(wr_en && wr_idx == '0)); // R3
endmodule

bind i2c_paged_regs i2c_paged_regs_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
    .page(page)
);

// File: tb/sim_i2c_paged_regs.sv
`timescale 1ns/1ps
// Directed bench: a bit-level I2C host model drives the target; results are
// checked against values derived from the requirements.
module sim_i2c_paged_regs;
    localparam logic [6:0] ADDR = 7'h18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_line = 1'b1;
    logic       host_low = 1'b0;
    logic       sda_oe;
    logic       sda_line;
    logic       core_rd_page = 1'b0;
    logic [3:0] core_rd_idx = '0;
    logic [7:0] core_rd_data;
    logic       st_we = 1'b0;
    logic       st_page = 1'b0;
    logic [3:0] st_idx = '0;
    logic [7:0] st_data = '0;
    int         n_chk = 0;
    int         n_fail = 0;

    assign sda_line = ~(host_low | sda_oe);

    always #2 clk = ~clk;

    i2c_paged_regs u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .sda_oe(sda_oe), .core_rd_page(core_rd_page), .core_rd_idx(core_rd_idx),
        .core_rd_data(core_rd_data), .st_we(st_we), .st_page(st_page),
        .st_idx(st_idx), .st_data(st_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq;
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic h_start;
        host_low = 1'b0; wq; scl_line = 1'b1; wq; host_low = 1'b1; wq; scl_line = 1'b0;
    endtask

    task automatic h_stop;
        wq; host_low = 1'b1; wq; scl_line = 1'b1; wq; host_low = 1'b0; wq;
    endtask

    task automatic h_bit(input logic b, output logic seen);
        wq; host_low = ~b; wq; scl_line = 1'b1; wq; seen = sda_line; wq; scl_line = 1'b0;
    endtask

    task automatic h_bits(input logic [7:0] b, input int n);
        logic s;
        for (int k = 7; k > 7 - n; k--) h_bit(b[k], s);
    endtask

    task automatic h_wbyte(input logic [7:0] b, output logic ack);
        logic s;
        h_bits(b, 8);
        h_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic h_rbyte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int k = 7; k >= 0; k--) begin
            h_bit(1'b1, s);
            b[k] = s;
        end
        h_bit(~give_ack, s);
    endtask

    // Write n bytes (MSB-first in dat) starting at pointer p; returns ACK count.
    task automatic reg_write(input logic [7:0] p, input logic [31:0] dat,
                             input int n, output int acks);
        logic a;
        acks = 0;
        h_start;
        h_wbyte({ADDR, 1'b0}, a); acks += int'(a);
        h_wbyte(p, a);            acks += int'(a);
        for (int k = 0; k < n; k++) begin
            h_wbyte(dat[31-8*k -: 8], a);
            acks += int'(a);
        end
        h_stop;
    endtask

    // Read n bytes from the current pointer; last byte NACKed.
    task automatic cur_read(input int n, input logic set_ptr, input logic [7:0] p,
                            output logic [31:0] got);
        logic a;
        logic [7:0] b;
        got = '0;
        if (set_ptr) begin
            h_start;
            h_wbyte({ADDR, 1'b0}, a);
            h_wbyte(p, a);
        end
        h_start;
        h_wbyte({ADDR, 1'b1}, a);
        for (int k = 0; k < n; k++) begin
            h_rbyte(k != n - 1, b);
            got[31-8*k -: 8] = b;
        end
        h_stop;
    endtask

    task automatic core_peek(input logic pg, input logic [3:0] idx, output logic [7:0] v);
        core_rd_page = pg; core_rd_idx = idx;
        #1;
        v = core_rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R9 sda released", int'(sda_oe), 0);
        core_peek(1'b0, 4'd0, v); chk("R9 page", int'(v), 0);
        core_peek(1'b1, 4'd3, v); chk("R9 reg", int'(v), 0);
    endtask

    task automatic t_write_read;
        int a;
        logic [31:0] g;
        logic [7:0] v;
        reg_write(8'h02, 32'hA53CF069, 4, a);
        chk("R1 R2 acks", a, 6);
        core_peek(1'b0, 4'd2, v); chk("R10 idx2", int'(v), 'hA5);
        core_peek(1'b0, 4'd5, v); chk("R2 idx5", int'(v), 'h69);
        cur_read(3, 1'b1, 8'h02, g);
        chk("R6 burst read", int'(g[31:8]), 'hA53CF0);
        cur_read(1, 1'b0, 8'h00, g);
        chk("R6 nack keeps ptr", int'(g[31:24]), 'hF0);
    endtask

    task automatic t_mismatch;
        logic a;
        int acks = 0;
        logic [7:0] v;
        h_start;
        h_wbyte({7'h19, 1'b0}, a); acks += int'(a);
        h_wbyte(8'h05, a);         acks += int'(a);
        h_wbyte(8'h77, a);         acks += int'(a);
        h_stop;
        chk("R1 no ack", acks, 0);
        core_peek(1'b0, 4'd5, v); chk("R1 ignored", int'(v), 'h69);
    endtask

    task automatic t_pages;
        int a;
        logic [31:0] g;
        logic [7:0] v;
        reg_write(8'h00, 32'h01000000, 1, a);
        reg_write(8'h02, 32'h5A000000, 1, a);
        core_peek(1'b1, 4'd2, v); chk("R4 page1 idx2", int'(v), 'h5A);
        core_peek(1'b0, 4'd2, v); chk("R4 page0 idx2", int'(v), 'hA5);
        cur_read(1, 1'b1, 8'h00, g);
        chk("R3 page readback", int'(g[31:24]), 'h01);
        reg_write(8'h00, 32'hFE000000, 1, a);
        cur_read(1, 1'b1, 8'h00, g);
        chk("R3 bit0 only", int'(g[31:24]), 'h00);
    endtask

    task automatic t_readonly;
        int a;
        logic [7:0] v;
        @(posedge clk); #1;
        st_we = 1'b1; st_page = 1'b0; st_idx = 4'd14; st_data = 8'h81;
        @(posedge clk); #1;
        st_page = 1'b1; st_idx = 4'd15; st_data = 8'h5C;
        @(posedge clk); #1;
        st_we = 1'b0;
        reg_write(8'h0E, 32'h11220100, 3, a);
        chk("R5 acks", a, 5);
        core_peek(1'b0, 4'd14, v); chk("R5 ro idx14", int'(v), 'h81);
        core_peek(1'b0, 4'd15, v); chk("R5 ro idx15", int'(v), 'h00);
        core_peek(1'b0, 4'd0, v);  chk("R2 wrap to page", int'(v), 'h01);
    endtask

    task automatic t_abort;
        logic a;
        logic [31:0] g;
        logic [7:0] v;
        h_start;
        h_wbyte({ADDR, 1'b0}, a);
        h_wbyte(8'h06, a);
        h_bits(8'hC3, 4);
        h_start;
        h_wbyte({ADDR, 1'b0}, a);
        h_wbyte(8'h07, a);
        h_wbyte(8'h3E, a);
        h_stop;
        core_peek(1'b1, 4'd6, v); chk("R7 cut byte", int'(v), 'h00);
        core_peek(1'b1, 4'd7, v); chk("R7 restart", int'(v), 'h3E);
        h_start;
        h_wbyte({ADDR, 1'b0}, a);
        h_bits(8'h0A, 3);
        h_stop;
        chk("R7 stop releases", int'(sda_oe), 0);
        cur_read(1, 1'b1, 8'h07, g);
        chk("R7 after stop", int'(g[31:24]), 'h3E);
        cur_read(2, 1'b1, 8'h0F, g);
        chk("R5 R6 wrap read", int'(g[31:16]), 'h5C01);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        t_reset;
        t_write_read;
        t_mismatch;
        t_pages;
        t_readonly;
        t_abort;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R7 watchdog act=running exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule